// File: doc/BRIEF.md
# Debug port serial shift unit

This block is the serial access port of a processor debug system. A single 35-bit shift register takes frames from a serial data pin, most significant bit first. The shift clock is either a dedicated debug clock pin or the system clock, chosen by a mode input. A frame opens with a start bit and has a mode bit that steers it one of two ways. A core frame is held for the processor core. The core picks it up as its next debug instruction, or reads it as debug data. A trap frame passes through the same register into a 9-bit trap control register. That register drives six trap enables, two breakpoint requests and a sync request to the core.

The core can also write a 32-bit word into the shift register. The debug host then clocks that word out on the serial output pin while it clocks in its next frame. A status output reports idle, busy, frame ready, or frozen. The frozen code 2'b11 overrides every other code.

The serial clock pin is assumed to be synchronous to `clk` already. Both serial edges are detected at `clk` rate. In system clock mode every `clk` cycle counts as one shift edge.

Top module: `dbg_shift_port`

## Requirements
- R1: During and after reset the trap enables, breakpoint and sync outputs are 0. Ready is 0, the status is 2'b00 and the serial output is 0.
- R2: A frame is 35 bits, sent most significant bit first. Bit 34 is the start bit (1), bit 33 is the mode (0 = core frame, 1 = trap frame), bit 32 is a control bit and bits 31:0 are the payload. When the 35th bit of a core frame is sampled, ready rises, `core_rdata` shows bits 31:0 and `core_ctrl` shows bit 32.
- R3: With `clk_mode`=0, a bit is sampled at each rising edge of `dclk_pin`. With `clk_mode`=1, a bit is sampled at every `clk` edge. A 0 sampled while no frame is in progress is ignored and starts no frame.
- R4: When the last bit of a trap frame is sampled, payload bits 8:0 load the trap control register: bits 5:0 go to `trap_en`, bits 7:6 to `brk_en` and bit 8 to `sync_req`. A trap frame does not set ready.
- R5: The trap control register changes only on trap frames. Core frames, core reads and core writes leave it unchanged.
- R6: A `core_fetch` or `core_read` pulse clears ready. A new start bit also clears ready.
- R7: If the last bit of a core frame is sampled in the same cycle as a fetch or read pulse, ready ends up set.
- R8: A `core_write` while idle loads bits 31:0 with `core_wdata` and bits 34:32 with 3'b100, and clears ready. In pin clock mode the next frame shifts these 35 bits out on `sdo`, most significant bit first. Just before the k-th rising edge of the frame (k = 0..34), `sdo` holds bit 34-k.
- R9: A `core_write` while a frame is being shifted is ignored. The received frame is unchanged.
- R10: `dbg_stat` is 2'b11 while `core_frozen` is 1. Otherwise it is 2'b10 while a frame is being shifted, 2'b01 while ready is set and 2'b00 when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_mode | input | 1 | Shift clock select: 0 = debug clock pin, 1 = system clock |
| dclk_pin | input | 1 | Debug shift clock pin (synchronous to clk) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| core_fetch | input | 1 | Core fetches a debug instruction (consumes frame) |
| core_read | input | 1 | Core reads debug data (consumes frame) |
| core_write | input | 1 | Core writes debug data into the shift register |
| core_wdata | input | 32 | Write data from the core |
| core_rdata | output | 32 | Payload of the shift register |
| core_ctrl | output | 1 | Control bit of the received frame |
| core_ready | output | 1 | A core frame is waiting |
| core_frozen | input | 1 | Core is in the frozen (debug) state |
| dbg_stat | output | 2 | Status: 11 frozen, 10 busy, 01 ready, 00 idle |
| trap_en | output | 6 | Trap enable outputs |
| brk_en | output | 2 | Breakpoint request outputs |
| sync_req | output | 1 | Sync request output |

## Verification
Two functions can fall in the same cycle. The final sample of a core frame can coincide with a core fetch or read that clears ready, and a start bit can coincide with the consumption of a pending frame. The bench runs in system clock mode, where the cycle of the 35th sample is known exactly, and drives `core_read` or `core_fetch` in that cycle. Ready must be set afterwards with the new payload visible. In a separate case it drives a start bit while a frame is pending and checks that ready has dropped after that edge.

// File: rtl/dsp_pkg.sv
// Package: shared widths, frame field positions and types for the
// debug port serial shift unit. Assumes MSB-first framing.
package dsp_pkg;
    localparam int FRAME_W   = 35;
    localparam int PAYLOAD_W = 32;
    localparam int N_TRAP    = 6;
    localparam int N_BRK     = 2;
    localparam int TRAP_W    = N_TRAP + N_BRK + 1;
    localparam int BIT_START = FRAME_W - 1;
    localparam int BIT_MODE  = FRAME_W - 2;
    localparam int BIT_CTRL  = FRAME_W - 3;
    localparam int CNT_W     = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_READY  = 2'b01,
        ST_BUSY   = 2'b10,
        ST_FROZEN = 2'b11
    } stat_e;

    typedef struct packed {
        logic              sync;
        logic [N_BRK-1:0]  brk;
        logic [N_TRAP-1:0] trap;
    } trap_ctl_t;
endpackage

// File: rtl/dsp_edge_gen.sv
// Shift edge generator. Produces one-cycle sample (rise) and drive (fall)
// strobes, either from a debug clock pin assumed synchronous to clk, or
// on every clk cycle when system clock mode is selected.
module dsp_edge_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_sys,
    input  logic pin_clk,
    output logic rise,
    output logic fall
);
    logic pin_q;

    // Purpose: remember the previous level of the debug clock pin.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_clk;
    end

    // Purpose: pick the edge strobes for the selected shift clock.
    always_comb begin
        if (mode_sys) begin
            rise = 1'b1;
            fall = 1'b1;
        end else begin
            rise = pin_clk & ~pin_q;
            fall = ~pin_clk & pin_q;
        end
    end

    a_r3_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_sys |-> !(rise && fall));
endmodule

// File: rtl/dsp_trap_reg.sv
// Trap control register. Loaded only by a load strobe from the shift
// core and never by the core bus. Drives trap enables, breakpoint
// requests and a sync request. Assumes load is a one-cycle strobe.
module dsp_trap_reg
    import dsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TRAP_W-1:0] din,
    output logic [N_TRAP-1:0] trap_en,
    output logic [N_BRK-1:0]  brk_en,
    output logic              sync_req
);
    trap_ctl_t ctl_q;

    // Purpose: capture the trap control field on a trap frame.
    always_ff @(posedge clk) begin
        if (!rst_n)    ctl_q <= '0;
        else if (load) ctl_q <= trap_ctl_t'(din);
    end

    assign trap_en  = ctl_q.trap;
    assign brk_en   = ctl_q.brk;
    assign sync_req = ctl_q.sync;

    a_r4_load_captures: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ({sync_req, brk_en, trap_en} == $past(din)));
    a_r5_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable({sync_req, brk_en, trap_en}));
endmodule

// File: rtl/dsp_shift_core.sv
// Shift core. Holds the 35-bit shift register, the bit counter, the
// ready flag and the serial output. A frame starts on a sampled 1 while
// idle and ends after FRAME_W samples. The core may parallel-load the
// register while idle. Assumes rise and fall are one-cycle strobes.
module dsp_shift_core
    import dsp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rise,
    input  logic                 fall,
    input  logic                 sdi,
    input  logic                 consume,
    input  logic                 wr_req,
    input  logic [PAYLOAD_W-1:0] wr_data,
    output logic [FRAME_W-1:0]   sr,
    output logic                 busy,
    output logic                 ready,
    output logic                 sdo,
    output logic                 trap_load,
    output logic [TRAP_W-1:0]    trap_data
);
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] sr_next;
    logic start_ev, shift_ev, last_ev, wr_ok;

    assign sr_next  = {sr[FRAME_W-2:0], sdi};
    assign start_ev = rise & sdi & ~busy;
    assign shift_ev = rise & busy;
    assign last_ev  = shift_ev & (cnt == CNT_W'(FRAME_W - 1));
    assign wr_ok    = wr_req & ~busy & ~start_ev;

    assign trap_load = last_ev & sr_next[BIT_MODE];
    assign trap_data = sr_next[TRAP_W-1:0];

    // Purpose: shift in frames, count bits, accept idle core writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr   <= '0;
            cnt  <= '0;
            busy <= 1'b0;
        end else if (start_ev) begin
            sr   <= sr_next;
            cnt  <= CNT_W'(1);
            busy <= 1'b1;
        end else if (shift_ev) begin
            sr   <= sr_next;
            cnt  <= last_ev ? '0 : cnt + CNT_W'(1);
            busy <= ~last_ev;
        end else if (wr_ok) begin
            sr   <= {3'b100, wr_data};
        end
    end

    // Purpose: ready flag; a finishing core frame wins over any clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ready <= 1'b0;
        else if (last_ev && !sr_next[BIT_MODE])
            ready <= 1'b1;
        else if (start_ev || wr_ok || consume)
            ready <= 1'b0;
    end

    // Purpose: serial output follows the top bit when idle, else on fall.
    always_ff @(posedge clk) begin
        if (!rst_n)            sdo <= 1'b0;
        else if (!busy || fall) sdo <= sr[FRAME_W-1];
    end

    a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(FRAME_W));
    a_r2_ready_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(busy));
    a_r6_start_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> !ready);
    a_r7_finish_beats_consume: assert property (@(posedge clk) disable iff (!rst_n)
        (last_ev && !sr_next[BIT_MODE] && consume) |=> ready);
    a_r8_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (sr[FRAME_W-1:PAYLOAD_W] == 3'b100) && !ready);
    a_r9_write_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && busy && !rise) |=> $stable(sr));
    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ready);
endmodule

// File: rtl/dbg_shift_port.sv
// Debug port serial shift unit, top level. Joins the edge generator, the
// shift core and the trap control register, and encodes the status.
// Assumes dclk_pin and sdi are synchronous to clk.
module dbg_shift_port
    import dsp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clk_mode,
    input  logic                 dclk_pin,
    input  logic                 sdi,
    output logic                 sdo,
    input  logic                 core_fetch,
    input  logic                 core_read,
    input  logic                 core_write,
    input  logic [PAYLOAD_W-1:0] core_wdata,
    output logic [PAYLOAD_W-1:0] core_rdata,
    output logic                 core_ctrl,
    output logic                 core_ready,
    input  logic                 core_frozen,
    output logic [1:0]           dbg_stat,
    output logic [N_TRAP-1:0]    trap_en,
    output logic [N_BRK-1:0]     brk_en,
    output logic                 sync_req
);
    logic               rise, fall, busy, ready, t_load;
    logic [FRAME_W-1:0] sr;
    logic [TRAP_W-1:0]  t_data;
    stat_e              stat;

    dsp_edge_gen u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sys (clk_mode),
        .pin_clk  (dclk_pin),
        .rise     (rise),
        .fall     (fall)
    );

    dsp_shift_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .fall      (fall),
        .sdi       (sdi),
        .consume   (core_fetch | core_read),
        .wr_req    (core_write),
        .wr_data   (core_wdata),
        .sr        (sr),
        .busy      (busy),
        .ready     (ready),
        .sdo       (sdo),
        .trap_load (t_load),
        .trap_data (t_data)
    );

    dsp_trap_reg u_trap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .din      (t_data),
        .trap_en  (trap_en),
        .brk_en   (brk_en),
        .sync_req (sync_req)
    );

    assign core_rdata = sr[PAYLOAD_W-1:0];
    assign core_ctrl  = sr[BIT_CTRL];
    assign core_ready = ready;

    // Purpose: status code; frozen overrides busy, which overrides ready.
    always_comb begin
        if (core_frozen) stat = ST_FROZEN;
        else if (busy)   stat = ST_BUSY;
        else if (ready)  stat = ST_READY;
        else             stat = ST_IDLE;
    end
    assign dbg_stat = stat;

    a_r5_trap_only_trap_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $changed({sync_req, brk_en, trap_en}) |-> $past(busy));
endmodule

// File: tb/test_dbg_shift_port.sv
module test_dbg_shift_port;
    localparam int CLK_P = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        clk_mode = 1'b1, dclk_pin = 1'b0, sdi = 1'b0;
    logic        core_fetch = 1'b0, core_read = 1'b0, core_write = 1'b0;
    logic [31:0] core_wdata = '0;
    logic        core_frozen = 1'b0;
    logic        sdo, core_ctrl, core_ready, sync_req;
    logic [31:0] core_rdata;
    logic [1:0]  dbg_stat, brk_en;
    logic [5:0]  trap_en;

    int checks = 0, fails = 0;
    logic [8:0] exp_trap = '0;

    dbg_shift_port i_dbg_shift_port (.*);

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [34:0] mk_frame(logic mode, logic ctl, logic [31:0] pl);
        return {1'b1, mode, ctl, pl};
    endfunction

    function automatic logic [8:0] trap_now();
        return {sync_req, brk_en, trap_en};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic pulse_fetch(); core_fetch = 1'b1; tick(); core_fetch = 1'b0; endtask
    task automatic pulse_read();  core_read  = 1'b1; tick(); core_read  = 1'b0; endtask
    task automatic pulse_write(logic [31:0] d);
        core_wdata = d; core_write = 1'b1; tick(); core_write = 1'b0;
    endtask

    // System clock mode frame; optionally consume in the last sample cycle
    // and optionally check that the start bit cleared ready.
    task automatic send_sys(logic [34:0] f, bit consume_last, bit chk_start);
        clk_mode = 1'b1;
        for (int i = 34; i >= 0; i--) begin
            sdi = f[i];
            if (i == 0 && consume_last) core_read = 1'b1;
            tick();
            core_read = 1'b0;
            if (i == 34 && chk_start) begin
                check("R6 start clears ready", core_ready, 1'b0);
                check("R10 busy status", dbg_stat, 2'b10);
            end
        end
        sdi = 1'b0;
    endtask

    // Pin clock mode frame; captures sdo before each rising edge and
    // tries a core write in the middle of the frame.
    task automatic send_pin(logic [34:0] f, output logic [34:0] cap);
        clk_mode = 1'b0;
        for (int i = 34; i >= 0; i--) begin
            sdi = f[i]; dclk_pin = 1'b0;
            tick(); tick();
            cap[i] = sdo;
            if (i == 17) begin
                check("R10 busy mid frame", dbg_stat, 2'b10);
                pulse_write(32'hDEAD_BEEF);
            end
            dclk_pin = 1'b1;
            tick(); tick();
        end
        dclk_pin = 1'b0; sdi = 1'b0;
        tick(); tick();
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] pl, w;
        logic [34:0] cap;
        logic        ct;
        void'($urandom(32'd2024));
        repeat (3) tick();
        // R1: reset state
        check("R1 trap reset", trap_now(), 9'h0);
        check("R1 ready reset", core_ready, 1'b0);
        check("R1 stat reset", dbg_stat, 2'b00);
        rst_n = 1'b1;
        tick();
        check("R1 sdo reset", sdo, 1'b0);

        // R3: zeros while idle start nothing
        repeat (10) tick();
        check("R3 idle zeros ignored", dbg_stat, 2'b00);

        // R2/R5/R6/R10: random core frames in system clock mode
        for (int n = 0; n < 8; n++) begin
            pl = $urandom(); ct = 1'($urandom());
            send_sys(mk_frame(1'b0, ct, pl), 1'b0, 1'b0);
            check("R2 ready set", core_ready, 1'b1);
            check("R2 payload", core_rdata, pl);
            check("R2 ctrl bit", core_ctrl, ct);
            check("R10 ready status", dbg_stat, 2'b01);
            check("R5 core frame keeps trap", trap_now(), exp_trap);
            if (n % 2 == 0) pulse_fetch(); else pulse_read();
            check("R6 consume clears ready", core_ready, 1'b0);
            check("R5 consume keeps trap", trap_now(), exp_trap);
        end

        // R4: random trap frames
        for (int n = 0; n < 6; n++) begin
            pl = $urandom();
            send_sys(mk_frame(1'b1, 1'b0, pl), 1'b0, 1'b0);
            exp_trap = pl[8:0];
            check("R4 trap load", trap_now(), exp_trap);
            check("R4 no ready", core_ready, 1'b0);
        end

        // R6: start bit clears a pending frame
        pl = $urandom();
        send_sys(mk_frame(1'b0, 1'b1, pl), 1'b0, 1'b0);
        check("R2 pending", core_ready, 1'b1);
        pl = $urandom();
        send_sys(mk_frame(1'b0, 1'b0, pl), 1'b0, 1'b1);
        check("R2 after restart", core_rdata, pl);

        // R7: finish and consume in the same cycle
        pulse_read();
        pl = $urandom();
        send_sys(mk_frame(1'b0, 1'b1, pl), 1'b1, 1'b0);
        check("R7 ready survives consume", core_ready, 1'b1);
        check("R7 payload", core_rdata, pl);

        // R10: frozen overrides
        core_frozen = 1'b1; #1;
        check("R10 frozen status", dbg_stat, 2'b11);
        core_frozen = 1'b0; #1;
        check("R10 unfrozen status", dbg_stat, 2'b01);

        // R8/R5: core write while idle
        w = $urandom();
        pulse_write(w);
        check("R8 write clears ready", core_ready, 1'b0);
        check("R8 write data", core_rdata, w);
        check("R5 write keeps trap", trap_now(), exp_trap);
        tick();

        // R8/R9/R3: pin-mode frame shifting the written word out
        pl = $urandom();
        send_pin(mk_frame(1'b0, 1'b0, pl), cap);
        check("R8 sdo stream", cap, {3'b100, w});
        check("R9 write ignored in frame", core_rdata, pl);
        check("R3 pin mode ready", core_ready, 1'b1);

        // R4 in pin mode
        pl = $urandom();
        send_pin(mk_frame(1'b1, 1'b1, pl), cap);
        exp_trap = pl[8:0];
        check("R4 pin trap load", trap_now(), exp_trap);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule